// File: doc/BRIEF.md
# E3 G.832 Transmit Overhead Inserter

This block builds the transmit byte stream of an E3 G.832 frame. A position counter walks through the frame one octet per clock. At every position it either takes a payload octet from the upstream data port or puts one of the seven overhead octets in its place: the two alignment octets, the error-monitoring octet, the trail trace octet, the maintenance octet, and the network operator and general-purpose octets. Each overhead octet has its own source. It can come from a fixed pattern, from an internal generator, from a byte-wide external overhead port that is sampled in that octet's slot, or from the data port itself when the whole frame is supplied from upstream.

The block computes the even-parity BIP-8 over every octet it sends, and places it in the error-monitoring octet of the next frame. It also resolves the remote defect bit and the remote error bit of the maintenance octet from configuration, receiver status and external inputs. The upstream side supplies a valid octet whenever `in_ready` is high. The line side receives one registered octet per clock, with a start-of-frame marker on the first octet.

Top module: `tx_g832_oh_inserter`

## Requirements
- R1: A frame is FRAME_LEN octets long (default 537). `out_sof` is high exactly with the octet from position 0. The seven overhead octets sit at the positions in the OH_POS table, in the order alignment-1, alignment-2, error-monitoring, trail-trace, maintenance, network-operator, general-purpose. All other positions carry payload.
- R2: With `cfg_ext_dat`=0, `in_ready` is high in payload positions and low in overhead positions. An octet taken while `in_ready` is high appears on `out_byte` one clock later.
- R3: With `cfg_ext_dat`=1, `in_ready` is high in every position, and every octet, overhead included, is copied unchanged from `in_byte`.
- R4: With `cfg_ext_dat`=0, the alignment octets are 8'hF6 and 8'h28 when `cfg_ext_frm`=0. They are taken from `ext_oh` when `cfg_ext_frm`=1.
- R5: With `cfg_ext_dat`=0, the error-monitoring octet is the bitwise XOR of all octets sent in the previous complete frame, overhead included. In the first frame after reset it is 8'h00.
- R6: With `cfg_ext_dat`=0, the trail trace octet is `ext_oh` when `cfg_ext_tr`=1 and 8'h00 otherwise.
- R7: The remote defect bit is bit 7 of the maintenance octet. With `cfg_ext_dat`=0 it is resolved in priority order. It is 1 whenever `cfg_force_rdi`=1. Otherwise, when `cfg_auto_rdi`=1, it is `los | oof`. Otherwise, when `cfg_ext_rdi`=1, it is `ext_oh[7]`. Otherwise it is 0.
- R8: The remote error bit is bit 6 of the maintenance octet. With `cfg_ext_dat`=0 it is `ext_oh[6]` when `cfg_ext_rei`=1. Otherwise it is 1 if `rei_req` was high in any cycle since the previous maintenance slot, or in the maintenance slot itself. The maintenance slot always clears this pending request, whatever the mode.
- R9: With `cfg_ext_dat`=0, maintenance bits 5..0 and the network-operator and general-purpose octets are 8'h00 / zero.
- R10: While `rst_n` is low, `out_byte` is 8'h00 and `out_sof` is 0. The first position after reset is position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_byte | input | 8 | Upstream octet, valid whenever in_ready is high |
| in_ready | output | 1 | In_byte is consumed this cycle |
| ext_oh | input | 8 | External overhead octet, sampled in the current overhead slot |
| cfg_ext_dat | input | 1 | Whole frame, overhead included, comes from in_byte |
| cfg_ext_frm | input | 1 | Alignment octets from ext_oh |
| cfg_ext_tr | input | 1 | Trail trace octet from ext_oh |
| cfg_ext_rdi | input | 1 | Remote defect bit from ext_oh[7] |
| cfg_auto_rdi | input | 1 | Remote defect bit follows los or oof |
| cfg_force_rdi | input | 1 | Remote defect bit forced to 1 |
| cfg_ext_rei | input | 1 | Remote error bit from ext_oh[6] |
| los | input | 1 | Receiver loss of signal |
| oof | input | 1 | Receiver out of frame |
| rei_req | input | 1 | Receiver BIP error, requests one remote error indication |
| out_byte | output | 8 | Transmit octet |
| out_sof | output | 1 | High with the first octet of each frame |

## Verification
The bench uses a short frame with a scattered overhead table. It sweeps all 128 combinations of the seven configuration bits, and for each one it checks every octet against a model built from the requirements. The error-monitoring octet is the main target. A design that left out the overhead from the parity, used the current frame instead of the previous one, or cleared the wrong register would send a wrong value in every frame after the first.

The remote defect priority is hit with every pairing of the force, automatic and external bits against varying status and external bits. A design with the priority reversed would follow `ext_oh` while alarms are forced. The remote error request is pulsed at positions both inside and away from the maintenance slot, so a design that loses a request raised in the slot itself, or repeats one for a second frame, sends the wrong bit. A reset in the middle of a run checks that the first error-monitoring octet afterwards is zero again.

// File: rtl/tx_oh_pkg.sv
package tx_oh_pkg;

    localparam int OH_COUNT = 7;

    localparam logic [7:0] ALIGN1_PAT = 8'hF6;
    localparam logic [7:0] ALIGN2_PAT = 8'h28;

    localparam int RDI_BIT = 7;
    localparam int REI_BIT = 6;

    // Slot codes follow the overhead table order, payload is 0
    typedef enum logic [2:0] {
        SLOT_PAY   = 3'd0,
        SLOT_FA1   = 3'd1,
        SLOT_FA2   = 3'd2,
        SLOT_EM    = 3'd3,
        SLOT_TR    = 3'd4,
        SLOT_MA    = 3'd5,
        SLOT_NR    = 3'd6,
        SLOT_GC    = 3'd7
    } slot_e;

    typedef struct packed {
        logic [7:0] data;
        logic       sof;
        logic       rei_pend;
    } tx_state_t;

endpackage

// File: rtl/tx_oh_slot_track.sv
module tx_oh_slot_track
    import tx_oh_pkg::*;
#(
    parameter int unsigned FRAME_LEN = 537,
    parameter int unsigned OH_POS [OH_COUNT] = '{0, 1, 60, 120, 180, 240, 300},
    localparam int POS_W = $clog2(FRAME_LEN)
) (
    input  logic  clk,
    input  logic  rst_n,
    output slot_e slot,
    output logic  frame_first,
    output logic  frame_last
);

    logic [POS_W-1:0]    pos_d, pos_q;
    logic [OH_COUNT-1:0] hit;

    for (genvar g = 0; g < OH_COUNT; g++) begin : g_hit
        assign hit[g] = (pos_q == POS_W'(OH_POS[g]));
    end

    always_comb begin
        slot = SLOT_PAY;
        for (int i = 0; i < OH_COUNT; i++) begin
            if (hit[i]) slot = slot_e'(3'(i + 1));
        end
    end

    assign frame_first = (pos_q == '0);
    assign frame_last  = (pos_q == POS_W'(FRAME_LEN - 1));

    always_comb begin
        pos_d = frame_last ? '0 : pos_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_last |=> frame_first); // R1

    AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_last |=> !frame_first); // R1

endmodule

// File: rtl/tx_bip8_gen.sv
module tx_bip8_gen #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] octet,
    input  logic         frame_last,
    output logic [W-1:0] parity
);

    logic [W-1:0] acc_d, acc_q;
    logic [W-1:0] hold_d, hold_q;

    always_comb begin
        acc_d  = acc_q ^ octet;
        hold_d = hold_q;
        if (frame_last) begin
            hold_d = acc_q ^ octet;
            acc_d  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            hold_q <= '0;
        end else begin
            acc_q  <= acc_d;
            hold_q <= hold_d;
        end
    end

    assign parity = hold_q;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_last |=> $stable(hold_q)); // R5

    AST_ACC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        frame_last |=> (acc_q == '0)); // R5

endmodule

// File: rtl/tx_g832_oh_inserter.sv
module tx_g832_oh_inserter
    import tx_oh_pkg::*;
#(
    parameter int unsigned FRAME_LEN = 537,
    parameter int unsigned OH_POS [OH_COUNT] = '{0, 1, 60, 120, 180, 240, 300}
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_byte,
    output logic       in_ready,
    input  logic [7:0] ext_oh,
    input  logic       cfg_ext_dat,
    input  logic       cfg_ext_frm,
    input  logic       cfg_ext_tr,
    input  logic       cfg_ext_rdi,
    input  logic       cfg_auto_rdi,
    input  logic       cfg_force_rdi,
    input  logic       cfg_ext_rei,
    input  logic       los,
    input  logic       oof,
    input  logic       rei_req,
    output logic [7:0] out_byte,
    output logic       out_sof
);

    slot_e      slot;
    logic       frame_first, frame_last;
    logic [7:0] bip_hold;
    logic [7:0] sel;
    logic       rdi_bit, rei_bit;
    tx_state_t  st_d, st_q;

    tx_oh_slot_track #(
        .FRAME_LEN (FRAME_LEN),
        .OH_POS    (OH_POS)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot        (slot),
        .frame_first (frame_first),
        .frame_last  (frame_last)
    );

    assign in_ready = cfg_ext_dat || (slot == SLOT_PAY);

    always_comb begin
        // Remote defect: force beats automatic beats external
        if (cfg_force_rdi)     rdi_bit = 1'b1;
        else if (cfg_auto_rdi) rdi_bit = los | oof;
        else if (cfg_ext_rdi)  rdi_bit = ext_oh[RDI_BIT];
        else                   rdi_bit = 1'b0;

        rei_bit = cfg_ext_rei ? ext_oh[REI_BIT] : (st_q.rei_pend | rei_req);

        sel = 8'h00;
        unique case (slot)
            SLOT_PAY: sel = in_byte;
            SLOT_FA1: sel = cfg_ext_frm ? ext_oh : ALIGN1_PAT;
            SLOT_FA2: sel = cfg_ext_frm ? ext_oh : ALIGN2_PAT;
            SLOT_EM:  sel = bip_hold;
            SLOT_TR:  sel = cfg_ext_tr ? ext_oh : 8'h00;
            SLOT_MA: begin
                sel[RDI_BIT] = rdi_bit;
                sel[REI_BIT] = rei_bit;
            end
            SLOT_NR:  sel = 8'h00;
            SLOT_GC:  sel = 8'h00;
            default:  sel = 8'h00;
        endcase
        if (cfg_ext_dat) sel = in_byte;
    end

    tx_bip8_gen #(.W(8)) u_bip (
        .clk        (clk),
        .rst_n      (rst_n),
        .octet      (sel),
        .frame_last (frame_last),
        .parity     (bip_hold)
    );

    always_comb begin
        st_d          = st_q;
        st_d.data     = sel;
        st_d.sof      = frame_first;
        st_d.rei_pend = (slot == SLOT_MA) ? 1'b0 : (st_q.rei_pend | rei_req);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_byte = st_q.data;
    assign out_sof  = st_q.sof;

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> (out_byte == $past(in_byte))); // R2

    AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |=> !out_sof); // R1

    AST_ALIGN_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_FA1 && !cfg_ext_dat && !cfg_ext_frm) |=> (out_byte == ALIGN1_PAT)); // R4

    AST_EM_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_EM && !cfg_ext_dat) |=> (out_byte == $past(bip_hold))); // R5

    AST_TR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_TR && !cfg_ext_dat && !cfg_ext_tr) |=> (out_byte == 8'h00)); // R6

    AST_RDI_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_MA && !cfg_ext_dat && cfg_force_rdi) |=> out_byte[RDI_BIT]); // R7

    AST_REI_REQ_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_MA && !cfg_ext_dat && !cfg_ext_rei && rei_req) |=> out_byte[REI_BIT]); // R8

    AST_MA_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_MA && !cfg_ext_dat) |=> (out_byte[5:0] == 6'd0)); // R9

endmodule

// File: tb/tb_tx_g832_oh_inserter.sv
`timescale 1ns/1ps
module tb_tx_g832_oh_inserter;

    localparam int LEN = 16;
    localparam int unsigned OHP [7] = '{0, 1, 3, 5, 8, 11, 14};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_byte = '0;
    logic       in_ready;
    logic [7:0] ext_oh = '0;
    logic       cfg_ext_dat = 0, cfg_ext_frm = 0, cfg_ext_tr = 0, cfg_ext_rdi = 0;
    logic       cfg_auto_rdi = 0, cfg_force_rdi = 0, cfg_ext_rei = 0;
    logic       los = 0, oof = 0, rei_req = 0;
    logic [7:0] out_byte;
    logic       out_sof;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int         m_pos;
    int         cyc;
    logic [7:0] m_acc, m_hold;
    logic       m_pend;

    always #10 clk = ~clk;

    tx_g832_oh_inserter #(.FRAME_LEN(LEN), .OH_POS(OHP)) dut (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_ready(in_ready),
        .ext_oh(ext_oh), .cfg_ext_dat(cfg_ext_dat), .cfg_ext_frm(cfg_ext_frm),
        .cfg_ext_tr(cfg_ext_tr), .cfg_ext_rdi(cfg_ext_rdi), .cfg_auto_rdi(cfg_auto_rdi),
        .cfg_force_rdi(cfg_force_rdi), .cfg_ext_rei(cfg_ext_rei), .los(los), .oof(oof),
        .rei_req(rei_req), .out_byte(out_byte), .out_sof(out_sof)
    );

    function automatic int slot_of(int p);
        int s = 0;
        for (int i = 0; i < 7; i++) if (p == int'(OHP[i])) s = i + 1;
        return s;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s pos %0d cyc %0d actual %0h expected %0h", req, m_pos, cyc, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 out_byte", out_byte, 0);
        check("R10 out_sof", out_sof, 0);
        rst_n  = 1'b1;
        m_pos  = 0;
        m_acc  = '0;
        m_hold = '0;
        m_pend = 1'b0;
    endtask

    // One octet position: drive at negedge, check output at the next negedge
    task automatic step();
        int         s;
        logic [7:0] exp;
        logic       rdi, rei;
        string      req;
        in_byte = 8'(cyc * 37 + 11);
        ext_oh  = 8'(cyc * 53 + 7) ^ 8'(cyc >> 4);
        los     = (cyc % 5) == 0;
        oof     = (cyc % 11) == 3;
        rei_req = (cyc % 13) == 4 || (cyc % 29) == 8;
        #1;
        s = slot_of(m_pos);
        check(cfg_ext_dat ? "R3 in_ready" : "R2 in_ready", int'(in_ready),
              int'(cfg_ext_dat || s == 0));
        if (cfg_force_rdi)     rdi = 1'b1;
        else if (cfg_auto_rdi) rdi = los | oof;
        else if (cfg_ext_rdi)  rdi = ext_oh[7];
        else                   rdi = 1'b0;
        rei = cfg_ext_rei ? ext_oh[6] : (m_pend | rei_req);
        case (s)
            0: begin exp = in_byte;                          req = "R2"; end
            1: begin exp = cfg_ext_frm ? ext_oh : 8'hF6;     req = "R4"; end
            2: begin exp = cfg_ext_frm ? ext_oh : 8'h28;     req = "R4"; end
            3: begin exp = m_hold;                           req = "R5"; end
            4: begin exp = cfg_ext_tr ? ext_oh : 8'h00;      req = "R6"; end
            5: begin exp = {rdi, rei, 6'd0};                 req = "R7 R8 R9"; end
            default: begin exp = 8'h00;                      req = "R9"; end
        endcase
        if (cfg_ext_dat) begin
            exp = in_byte;
            req = "R3";
        end
        m_pend = (s == 5) ? 1'b0 : (m_pend | rei_req);
        m_acc  = m_acc ^ exp;
        if (m_pos == LEN - 1) begin
            m_hold = m_acc;
            m_acc  = '0;
        end
        @(posedge clk);
        @(negedge clk);
        check(req, int'(out_byte), int'(exp));
        check("R1 out_sof", int'(out_sof), int'(m_pos == 0));
        m_pos = (m_pos + 1) % LEN;
        cyc++;
    endtask

    task automatic run_frames(int n);
        for (int k = 0; k < n * LEN; k++) step();
    endtask

    task automatic set_cfg(int c);
        cfg_ext_dat   = c[0];
        cfg_ext_frm   = c[1];
        cfg_ext_tr    = c[2];
        cfg_ext_rdi   = c[3];
        cfg_auto_rdi  = c[4];
        cfg_force_rdi = c[5];
        cfg_ext_rei   = c[6];
    endtask

    initial begin
        cyc = 0;
        do_reset();
        // R5: first frame after reset carries zero parity
        run_frames(2);
        for (int c = 0; c < 128; c++) begin
            set_cfg(c);
            run_frames(3);
        end
        // R10: reset in mid-run, parity restarts from zero
        set_cfg(7'b0010000);
        run_frames(1);
        do_reset();
        run_frames(3);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule